// File: doc/BRIEF.md
# Fully-Associative Read Cache with Counter-Stamped LRU

This block is a small read cache in which every line may live in any slot. On each request the tag is compared against all valid slots at once. A hit returns the stored word on the following cycle. A miss stalls the requester and fetches the whole line from a backing memory through a request/acknowledge handshake. It then installs the line in a chosen slot and returns the requested word.

Replacement is least-recently-used. A global access counter advances once for every completed access, whether a hit or a fill. The slot touched by that access records the counter value as its stamp. When a valid slot must be evicted, the slot with the smallest stamp goes. When the counter reaches its all-ones value, the block spends one stalled cycle compressing the stamps, so their relative order survives and the counter never wraps.

The block expects a reset that is asserted asynchronously and released in step with the clock.

Top module: `fa_lru_cache`

## Requirements
- R1: After reset no slot is valid, `rsp_valid` and `mem_req` are 0 and `req_ready` is 1, so the first access to any address misses.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. If its tag (the address above the word offset) matches any valid slot, `rsp_valid` and `rsp_hit` are 1 in the next cycle and `rsp_data` carries the stored word.
- R3: On a miss, `req_ready` drops to 0 and `mem_req` rises in the cycle after acceptance. `mem_line_addr` holds the request tag and stays stable until `mem_ack`. In the cycle after `mem_ack`, `rsp_valid` is 1, `rsp_hit` is 0 and `rsp_data` is the requested word of `mem_line`, with word k in bits [k*DATA_W +: DATA_W].
- R4: A miss fills an invalid slot, the lowest-numbered one, whenever any slot is invalid. No valid line is evicted while an empty slot remains.
- R5: Every completed access, hit or fill, writes the current global counter value into the touched slot's stamp and then increments the counter.
- R6: A miss with all slots valid evicts the slot with the smallest stamp. On equal stamps the lowest slot number wins.
- R7: When the global counter equals all ones and the block is idle, `req_ready` is 0 for exactly one cycle. In that cycle each valid stamp is replaced by its rank (its position counted from 0 among the valid stamps) and the counter is set to the number of valid slots, so eviction order is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_hit | output | 1 | Response came from a resident line |
| rsp_data | output | DATA_W | Requested word |
| mem_req | output | 1 | Line fetch request to backing memory |
| mem_line_addr | output | ADDR_W-log2(LINE_WORDS) | Line address being fetched |
| mem_ack | input | 1 | Backing memory delivers the line this cycle |
| mem_line | input | LINE_WORDS*DATA_W | Line contents, word 0 in the low bits |

## Verification
The assertions check the following on every cycle:
- The fetch handshake: the request stays stable until acknowledge, and the requester is stalled while a fetch is outstanding.
- Response timing for hits and fills.
- That at most one slot matches a tag.
- That a compression stall lasts a single cycle.

Which slot is evicted depends on the history of stamps, so only the bench's scenarios can show it. The bench's long access sequence shows the eviction order through later hit and miss outcomes, both before and after a stamp compression. A sequence after a mid-run reset shows that empty slots are filled first.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int N     = 4,
  parameter int TAG_W = 8,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        probe,
  output logic [N-1:0]            match_vec,
  output logic                    hit,
  output logic [IDX_W-1:0]        hit_idx
);
  // One comparator per slot, all evaluated in parallel
  for (genvar s = 0; s < N; s++) begin : g_cmp
    assign match_vec[s] = valid[s] && (tags[s] == probe);
  end

  assign hit = |match_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_line_store.sv
module fa_line_store #(
  parameter int N      = 4,
  parameter int TAG_W  = 8,
  parameter int LINE_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fill_en,
  input  logic [IDX_W-1:0]         fill_idx,
  input  logic [TAG_W-1:0]         fill_tag,
  input  logic [LINE_W-1:0]        fill_line,
  output logic [N-1:0]             valid_q,
  output logic [N-1:0][TAG_W-1:0]  tag_q,
  output logic [N-1:0][LINE_W-1:0] line_q
);
  for (genvar s = 0; s < N; s++) begin : g_slot
    logic wr_en;
    assign wr_en = fill_en && (fill_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
      end else if (wr_en) begin
        valid_q[s] <= 1'b1;
      end
    end

    // Payload registers carry no reset; valid qualifies them
    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q[s]  <= fill_tag;
        line_q[s] <= fill_line;
      end
    end
  end
endmodule

// File: rtl/fa_lru_stamp.sv
module fa_lru_stamp #(
  parameter int N       = 4,
  parameter int STAMP_W = 4,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic             need_rescale,
  output logic [IDX_W-1:0] victim_idx
);
  logic [N-1:0][STAMP_W-1:0] stamp_q, stamp_d;
  logic [STAMP_W-1:0]        gcnt_q, gcnt_d;
  logic [N-1:0][STAMP_W-1:0] rank;
  logic [STAMP_W-1:0]        nvalid;
  logic                      upd_en;
  logic                      inv_found;
  logic [IDX_W-1:0]          inv_idx;
  logic [IDX_W-1:0]          old_idx;
  logic [STAMP_W-1:0]        old_stamp;

  assign need_rescale = (gcnt_q == {STAMP_W{1'b1}});

  // Rank of each valid stamp among the valid stamps
  always_comb begin
    nvalid = '0;
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (valid[i] && valid[j] && (stamp_q[j] < stamp_q[i]))
          rank[i] = rank[i] + STAMP_W'(1);
      end
      if (valid[i]) nvalid = nvalid + STAMP_W'(1);
    end
  end

  // Victim choice: lowest empty slot, else oldest stamp (lowest index on tie)
  always_comb begin
    inv_found = 1'b0;
    inv_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        inv_found = 1'b1;
        inv_idx   = IDX_W'(i);
      end
    end
    old_idx   = '0;
    old_stamp = stamp_q[0];
    for (int i = 1; i < N; i++) begin
      if (stamp_q[i] < old_stamp) begin
        old_stamp = stamp_q[i];
        old_idx   = IDX_W'(i);
      end
    end
    victim_idx = inv_found ? inv_idx : old_idx;
  end

  // Next-state
  always_comb begin
    stamp_d = stamp_q;
    gcnt_d  = gcnt_q;
    if (touch_en) begin
      stamp_d[touch_idx] = gcnt_q;
      gcnt_d             = gcnt_q + STAMP_W'(1);
    end else if (need_rescale) begin
      for (int i = 0; i < N; i++) begin
        stamp_d[i] = valid[i] ? rank[i] : '0;
      end
      gcnt_d = nvalid;
    end
  end

  assign upd_en = touch_en || need_rescale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      gcnt_q  <= '0;
    end else if (upd_en) begin
      stamp_q <= stamp_d;
      gcnt_q  <= gcnt_d;
    end
  end
endmodule

// File: rtl/fa_lru_cache.sv
module fa_lru_cache #(
  parameter int NUM_SLOTS  = 4,
  parameter int LINE_WORDS = 1,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int STAMP_W    = 4
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         req_valid,
  input  logic [ADDR_W-1:0]                            req_addr,
  output logic                                         req_ready,
  output logic                                         rsp_valid,
  output logic                                         rsp_hit,
  output logic [DATA_W-1:0]                            rsp_data,
  output logic                                         mem_req,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]         mem_line_addr,
  input  logic                                         mem_ack,
  input  logic [LINE_WORDS*DATA_W-1:0]                 mem_line
);
  import fa_cache_pkg::*;

  localparam int OFF_BITS = $clog2(LINE_WORDS);
  localparam int OFF_W    = (OFF_BITS > 0) ? OFF_BITS : 1;
  localparam int TAG_W    = ADDR_W - OFF_BITS;
  localparam int LINE_W   = LINE_WORDS * DATA_W;
  localparam int IDX_W    = $clog2(NUM_SLOTS);

  fill_state_e state_q, state_d;

  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic              accept;
  logic              lookup_hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [NUM_SLOTS-1:0] match_vec;
  logic              fill_done;
  logic              touch_en;
  logic [IDX_W-1:0]  touch_idx;
  logic              need_rescale;
  logic [IDX_W-1:0]  victim_idx;

  logic [NUM_SLOTS-1:0]             valid_q;
  logic [NUM_SLOTS-1:0][TAG_W-1:0]  tag_q;
  logic [NUM_SLOTS-1:0][LINE_W-1:0] line_q;

  logic [TAG_W-1:0]  miss_tag_q;
  logic [OFF_W-1:0]  miss_off_q;
  logic [IDX_W-1:0]  victim_q;
  logic              miss_cap_en;

  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_hit_q, rsp_hit_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic [LINE_W-1:0] hit_line;
  logic [DATA_W-1:0] hit_word;
  logic [DATA_W-1:0] fill_word;

  // Address split
  assign req_tag = req_addr[ADDR_W-1:OFF_BITS];
  if (LINE_WORDS > 1) begin : g_off
    assign req_off = req_addr[OFF_BITS-1:0];
  end else begin : g_no_off
    assign req_off = '0;
  end

  assign req_ready = (state_q == ST_IDLE) && !need_rescale;
  assign accept    = req_valid && req_ready;
  assign fill_done = (state_q == ST_FILL) && mem_ack;

  fa_tag_match #(
    .N(NUM_SLOTS), .TAG_W(TAG_W), .IDX_W(IDX_W)
  ) u_match (
    .valid(valid_q), .tags(tag_q), .probe(req_tag),
    .match_vec(match_vec), .hit(lookup_hit), .hit_idx(hit_idx)
  );

  fa_line_store #(
    .N(NUM_SLOTS), .TAG_W(TAG_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_done), .fill_idx(victim_q),
    .fill_tag(miss_tag_q), .fill_line(mem_line),
    .valid_q(valid_q), .tag_q(tag_q), .line_q(line_q)
  );

  assign touch_en  = (accept && lookup_hit) || fill_done;
  assign touch_idx = fill_done ? victim_q : hit_idx;

  fa_lru_stamp #(
    .N(NUM_SLOTS), .STAMP_W(STAMP_W), .IDX_W(IDX_W)
  ) u_lru (
    .clk(clk), .rst_n(rst_n), .valid(valid_q),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .need_rescale(need_rescale), .victim_idx(victim_idx)
  );

  // Word selection for both response sources
  assign hit_line  = line_q[hit_idx];
  assign hit_word  = hit_line[int'(req_off)*DATA_W +: DATA_W];
  assign fill_word = mem_line[int'(miss_off_q)*DATA_W +: DATA_W];

  // Next-state
  always_comb begin
    state_d     = state_q;
    rsp_valid_d = 1'b0;
    rsp_hit_d   = rsp_hit_q;
    rsp_data_d  = rsp_data_q;
    miss_cap_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (lookup_hit) begin
            rsp_valid_d = 1'b1;
            rsp_hit_d   = 1'b1;
            rsp_data_d  = hit_word;
          end else begin
            miss_cap_en = 1'b1;
            state_d     = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          rsp_valid_d = 1'b1;
          rsp_hit_d   = 1'b0;
          rsp_data_d  = fill_word;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_cap_en) begin
      miss_tag_q <= req_tag;
      miss_off_q <= req_off;
      victim_q   <= victim_idx;
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_hit       = rsp_hit_q;
  assign rsp_data      = rsp_data_q;
  assign mem_req       = (state_q == ST_FILL);
  assign mem_line_addr = miss_tag_q;
endmodule

// File: rtl/fa_lru_cache_chk.sv
module fa_lru_cache_chk #(
  parameter int N     = 4,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [TAG_W-1:0] mem_line_addr,
  input logic [N-1:0]     match_vec
);
  // R3: an outstanding fetch stalls the requester
  assert_stall_on_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R3: fetch request held with a stable line address until acknowledged
  assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_line_addr)));

  // R3: acknowledge produces a miss response next cycle
  assert_fill_response_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (rsp_valid && !rsp_hit));

  // R2: a hit response follows an accepted request
  assert_hit_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $past(req_valid && req_ready));

  // R2: no two slots hold the same line
  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R7: a compression stall lasts one cycle
  assert_rescale_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_req) |=> req_ready);
endmodule

bind fa_lru_cache fa_lru_cache_chk #(
  .N(NUM_SLOTS), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_line_addr(mem_line_addr), .match_vec(match_vec)
);

// File: tb/fa_lru_cache_tb.sv
module fa_lru_cache_tb_top;
  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [7:0] req_addr;
  logic       req_ready;
  logic       rsp_valid;
  logic       rsp_hit;
  logic [7:0] rsp_data;
  logic       mem_req;
  logic [7:0] mem_line_addr;
  logic       mem_ack;
  logic [7:0] mem_line;

  int checks = 0;
  int errors = 0;

  fa_lru_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_data(rsp_data), .mem_req(mem_req), .mem_line_addr(mem_line_addr),
    .mem_ack(mem_ack), .mem_line(mem_line)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Backing memory contents: a fixed function of the line address
  function automatic logic [7:0] mem_word(input logic [7:0] a);
    return a * 8'd7 + 8'd3;
  endfunction

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Entered and left at a negative edge
  task automatic access(input logic [7:0] a, input int lat, input logic exp_hit,
                        input string rq);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      check({rq, " hit rsp_valid"}, rsp_valid, 1);
      check({rq, " hit flag"}, rsp_hit, 1);
      check({rq, " hit data"}, rsp_data, mem_word(a));
    end else begin
      check({rq, " miss no early rsp"}, rsp_valid, 0);
      check({rq, " R3 mem_req"}, mem_req, 1);
      check({rq, " R3 stalled"}, req_ready, 0);
      check({rq, " R3 line addr"}, mem_line_addr, a);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        check("R3 fetch held", mem_req, 1);
      end
      mem_ack  = 1'b1;
      mem_line = mem_word(mem_line_addr);
      @(negedge clk);
      mem_ack = 1'b0;
      check({rq, " R3 fill rsp_valid"}, rsp_valid, 1);
      check({rq, " R3 fill flag"}, rsp_hit, 0);
      check({rq, " R3 fill data"}, rsp_data, mem_word(a));
    end
  endtask

  // {address, expected hit, expected compression stall afterwards}
  localparam logic [9:0] VEC [22] = '{
    {8'd10, 1'b0, 1'b0}, {8'd20, 1'b0, 1'b0}, {8'd10, 1'b1, 1'b0},
    {8'd30, 1'b0, 1'b0}, {8'd40, 1'b0, 1'b0}, {8'd50, 1'b0, 1'b0},
    {8'd20, 1'b0, 1'b0}, {8'd30, 1'b1, 1'b0}, {8'd10, 1'b0, 1'b0},
    {8'd40, 1'b0, 1'b0}, {8'd50, 1'b0, 1'b0}, {8'd20, 1'b0, 1'b0},
    {8'd10, 1'b1, 1'b0}, {8'd40, 1'b1, 1'b0}, {8'd50, 1'b1, 1'b1},
    {8'd30, 1'b0, 1'b0}, {8'd20, 1'b0, 1'b0}, {8'd10, 1'b0, 1'b0},
    {8'd50, 1'b1, 1'b0}, {8'd40, 1'b0, 1'b0}, {8'd30, 1'b0, 1'b0},
    {8'd50, 1'b1, 1'b0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    mem_ack   = 1'b0;
    mem_line  = '0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1 rsp_valid in reset", rsp_valid, 0);
    check("R1 mem_req in reset", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", req_ready, 1);

    // Table walk: R2/R5/R6 order through hits and evictions, R7 compression
    for (int i = 0; i < 22; i++) begin
      access(VEC[i][9:2], i % 3, VEC[i][1], "R2/R6");
      if (VEC[i][0]) begin
        check("R7 compression stall", req_ready, 0);
        @(negedge clk);
        check("R7 stall ends", req_ready, 1);
      end
    end

    // R1: mid-run reset empties the cache
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset rsp_valid", rsp_valid, 0);
    check("R1 mid reset ready", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    access(8'd50, 1, 1'b0, "R1 cold miss");

    // R4: empty slots are used before any valid line is evicted
    access(8'd51, 0, 1'b0, "R4");
    access(8'd52, 2, 1'b0, "R4");
    access(8'd53, 0, 1'b0, "R4");
    access(8'd50, 0, 1'b1, "R4");
    access(8'd51, 0, 1'b1, "R4");
    access(8'd52, 0, 1'b1, "R4");
    access(8'd53, 0, 1'b1, "R4");
    // R5: stamps follow access order, so the oldest touch (50) goes next
    access(8'd60, 0, 1'b0, "R5");
    access(8'd51, 0, 1'b1, "R5");
    access(8'd50, 0, 1'b0, "R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule